// File: doc/BRIEF.md
# Counter-Driven Event Stream Generator

This block watches a free-running 64-bit counter value and emits a one-clock event pulse each time a chosen bit of that counter changes in a programmed direction. The resulting pulse train has a period that is a power of two of the counter tick, so it serves as a periodic wake-up or heartbeat that follows the counter's rate. Software sets the stream through one 32-bit control word, written and read over a plain write-enable and data port.

The control word holds an enable, an edge-polarity bit, a 4-bit bit-select and a scale bit. The scale bit moves the selection window up by eight bits, which is possible only when the extended-scale input is high. The word also stores two access-control bits for neighbouring logic. This block does not act on them. Any change to the settings re-arms the edge detector, so no false event follows a change.

Top module: `evs_event_gen`

## Requirements
- R1: After an asynchronous reset, `rd_data_o` reads 0 and `event_o` is 0.
- R2: A write with `wr_en_i` high updates the control word on that clock edge. Only these bits are writable: bit 17 (scale), bits 7:4 (select), bit 3 (direction), bit 2 (enable) and bits 1:0 (access-control). Every other bit reads 0, so writing 0xFFFFFFFF reads back 0x000200FF.
- R3: When the effective scale is 0, the trigger bit is counter bit `select`, in the range 0 to 15.
- R4: When direction is 0, a 0-to-1 change of the trigger bit produces an event. A 1-to-0 change does not.
- R5: When direction is 1, a 1-to-0 change of the trigger bit produces an event. A 0-to-1 change does not.
- R6: When enable is 0, `event_o` stays 0 for every counter activity.
- R7: When `ext_scale_i` is 1 and scale is 1, the trigger bit is counter bit `select + 8`, in the range 8 to 23. With select 15 this is bit 23.
- R8: When `ext_scale_i` is 0, the scale bit has no effect on selection. The trigger bit is then bit `select`.
- R9: In the cycle in which the enable, direction or effective trigger index changes, no event is produced, even if the newly selected bit differs from the stored previous bit.
- R10: A qualifying change of the counter between edges n and n+1 raises `event_o` for exactly one cycle after edge n+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Current control word |
| cnt_i | input | 64 | Free-running counter value |
| ext_scale_i | input | 1 | High when the shifted selection window is available |
| event_o | output | 1 | One-clock event pulse |

## Verification
If the stored previous trigger bit is wrong, the port shows a spurious or missing pulse one edge after the next counter change. If the re-arm logic is wrong, the port shows a false pulse one cycle after a configuration write that lands on a differing bit. An index or window fault appears as an event from the wrong counter bit, so the bench toggles neighbouring bits and checks that they give no event. A field-mask error appears on `rd_data_o` in the cycle after the write.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int unsigned RegW    = 32;
  localparam int unsigned CntW    = 64;
  localparam int unsigned SelW    = 4;
  localparam int unsigned ScaleSh = 8;
  localparam int unsigned TrapW   = 2;

  localparam int unsigned BitScale = 17;
  localparam int unsigned SelLsb   = 4;
  localparam int unsigned BitDir   = 3;
  localparam int unsigned BitEn    = 2;
  localparam int unsigned TrapLsb  = 0;

  localparam int unsigned WinW = 1 << SelW;
  localparam int unsigned IdxW = $clog2(ScaleSh + WinW);

  typedef struct packed {
    logic             scale;
    logic [SelW-1:0]  sel;
    logic             dir;
    logic             en;
    logic [TrapW-1:0] trap;
  } evs_cfg_t;

  function automatic logic [RegW-1:0] cfg_to_word(evs_cfg_t c);
    logic [RegW-1:0] w;
    w = '0;
    w[BitScale]                 = c.scale;
    w[SelLsb +: SelW]           = c.sel;
    w[BitDir]                   = c.dir;
    w[BitEn]                    = c.en;
    w[TrapLsb +: TrapW]         = c.trap;
    return w;
  endfunction

  function automatic evs_cfg_t word_to_cfg(logic [RegW-1:0] w);
    evs_cfg_t c;
    c.scale = w[BitScale];
    c.sel   = w[SelLsb +: SelW];
    c.dir   = w[BitDir];
    c.en    = w[BitEn];
    c.trap  = w[TrapLsb +: TrapW];
    return c;
  endfunction
endpackage

// File: rtl/evs_ctrl_reg.sv
module evs_ctrl_reg
  import evs_pkg::*;
#(
  parameter int unsigned REG_W = RegW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output evs_cfg_t         cfg_o
);
  evs_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (wr_en_i) cfg_q <= word_to_cfg(wr_data_i[RegW-1:0]);
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[RegW-1:0] = cfg_to_word(cfg_q);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/evs_trig_sel.sv
module evs_trig_sel #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned SHIFT = 8,
  localparam int unsigned WIN   = 1 << SEL_W,
  localparam int unsigned IDX_W = $clog2(SHIFT + WIN)
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             hi_i,
  output logic             bit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [WIN-1:0] win;

  // per-position window mux: low window or window shifted by SHIFT
  for (genvar i = 0; i < WIN; i++) begin : g_win
    assign win[i] = hi_i ? cnt_i[i+SHIFT] : cnt_i[i];
  end

  assign bit_o = win[sel_i];
  assign idx_o = IDX_W'(sel_i) + (hi_i ? IDX_W'(SHIFT) : IDX_W'(0));
endmodule

// File: rtl/evs_edge_det.sv
module evs_edge_det #(
  parameter int unsigned KEY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dir_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             bit_i,
  output logic             event_o
);
  logic             prev_q;
  logic [KEY_W-1:0] key_q;
  logic             evt_q;
  logic             rearm;
  logic             hit;

  assign rearm = (key_i != key_q);
  assign hit   = dir_i ? (prev_q & ~bit_i) : (~prev_q & bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      key_q  <= '0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= bit_i;
      key_q  <= key_i;
      evt_q  <= en_i & ~rearm & hit;
    end
  end

  assign event_o = evt_q;
endmodule

// File: rtl/evs_event_gen.sv
module evs_event_gen
  import evs_pkg::*;
#(
  parameter int unsigned REG_W = RegW,
  parameter int unsigned CNT_W = CntW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ext_scale_i,
  output logic             event_o
);
  localparam int unsigned KeyW = IdxW + 2;

  evs_cfg_t        cfg;
  logic            trig_bit;
  logic [IdxW-1:0] trig_idx;
  logic            hi_win;

  evs_ctrl_reg #(.REG_W(REG_W)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .cfg_o     (cfg)
  );

  assign hi_win = cfg.scale & ext_scale_i;

  evs_trig_sel #(.CNT_W(CNT_W), .SEL_W(SelW), .SHIFT(ScaleSh)) i_sel (
    .cnt_i (cnt_i),
    .sel_i (cfg.sel),
    .hi_i  (hi_win),
    .bit_o (trig_bit),
    .idx_o (trig_idx)
  );

  evs_edge_det #(.KEY_W(KeyW)) i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg.en),
    .dir_i   (cfg.dir),
    .key_i   ({cfg.en, cfg.dir, trig_idx}),
    .bit_i   (trig_bit),
    .event_o (event_o)
  );
endmodule

// File: rtl/evs_event_gen_chk.sv
module evs_event_gen_chk
  import evs_pkg::*;
#(
  parameter int unsigned REG_W = RegW,
  parameter int unsigned CNT_W = CntW
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] rd_data_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic             ext_scale_i,
  input logic             event_o
);
  localparam logic [RegW-1:0] WrMask = (RegW'(1) << BitScale) | (RegW'(WinW - 1) << SelLsb)
                                     | (RegW'(1) << BitDir) | (RegW'(1) << BitEn)
                                     | (RegW'((1 << TrapW) - 1) << TrapLsb);
  localparam logic [RegW-1:0] KeyMask = WrMask & ~(RegW'((1 << TrapW) - 1) << TrapLsb);

  int unsigned chk_idx;
  logic        chk_bit;

  always_comb begin
    chk_idx = int'(rd_data_o[SelLsb +: SelW]);
    if (rd_data_o[BitScale] && ext_scale_i) chk_idx = chk_idx + ScaleSh;
    chk_bit = cnt_i[chk_idx];
  end

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[RegW-1:0] & ~WrMask) == '0);

  // R6
  a_r6_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[BitEn] |=> !event_o);

  // R10
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);

  // R4 and R5: event only on a change toward the programmed level
  a_r4_edge_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> (($past(chk_bit) != $past(rd_data_o[BitDir])) && ($past(chk_bit, 2) != $past(chk_bit))));

  a_r9_rearm_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_data_o[RegW-1:0] & KeyMask) != ($past(rd_data_o[RegW-1:0]) & KeyMask)) |=> !event_o);
endmodule

bind evs_event_gen evs_event_gen_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) i_evs_event_gen_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_data_o   (rd_data_o),
  .cnt_i       (cnt_i),
  .ext_scale_i (ext_scale_i),
  .event_o     (event_o)
);

// File: tb/test_evs_event_gen.sv
module test_evs_event_gen;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [63:0] cnt = '0;
  logic        ext_scale = 1'b1;
  logic        evt;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evs_event_gen i_evs_event_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .cnt_i       (cnt),
    .ext_scale_i (ext_scale),
    .event_o     (evt)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge, then settles one cycle
  task automatic write_cfg(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  // set one counter bit at a negedge, check the pulse and its end
  task automatic poke(string req, int unsigned b, logic v, logic exp_evt);
    cnt[b] = v;
    @(negedge clk);
    check(req, 64'(evt), 64'(exp_evt));
    @(negedge clk);
    check({req, " end"}, 64'(evt), 64'(0));
  endtask

  task automatic t_reset();
    check("R1 rd_data", 64'(rd_data), 64'h0);
    check("R1 event", 64'(evt), 64'h0);
  endtask

  task automatic t_regs();
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 mask", 64'(rd_data), 64'h0002_00FF);
    write_cfg(32'h0);
    check("R2 clear", 64'(rd_data), 64'h0);
    write_cfg(32'h0002_0012);
    check("R2 pattern", 64'(rd_data), 64'h0002_0012);
  endtask

  task automatic t_rise();
    cnt = '0;
    write_cfg(32'h54); // en, dir 0, sel 5
    poke("R3 other bit", 4, 1'b1, 1'b0);
    poke("R4 rise", 5, 1'b1, 1'b1);
    poke("R4 fall ignored", 5, 1'b0, 1'b0);
    poke("R10 second rise", 5, 1'b1, 1'b1);
    check("R10 held bit", 64'(evt), 64'h0);
  endtask

  task automatic t_fall();
    cnt = '0;
    write_cfg(32'h5C); // en, dir 1, sel 5
    poke("R5 rise ignored", 5, 1'b1, 1'b0);
    poke("R5 fall", 5, 1'b0, 1'b1);
  endtask

  task automatic t_disabled();
    cnt = '0;
    write_cfg(32'h50);
    poke("R6 rise", 5, 1'b1, 1'b0);
    poke("R6 fall", 5, 1'b0, 1'b0);
  endtask

  task automatic t_scale();
    cnt = '0;
    ext_scale = 1'b1;
    write_cfg(32'h0002_0034); // scale, sel 3, en
    poke("R7 low bit ignored", 3, 1'b1, 1'b0);
    poke("R7 bit 11", 11, 1'b1, 1'b1);
    cnt = '0;
    write_cfg(32'h0002_00F4); // sel 15 -> bit 23
    poke("R7 bit 15 ignored", 15, 1'b1, 1'b0);
    poke("R7 bit 23", 23, 1'b1, 1'b1);
  endtask

  task automatic t_no_ext();
    cnt = '0;
    ext_scale = 1'b0;
    write_cfg(32'h0002_0034);
    poke("R8 bit 11 ignored", 11, 1'b1, 1'b0);
    poke("R8 bit 3", 3, 1'b1, 1'b1);
    ext_scale = 1'b1;
  endtask

  task automatic t_rearm();
    cnt = 64'h2; // bit0 = 0, bit1 = 1
    write_cfg(32'h04); // sel 0, rise
    wr_en = 1'b1; wr_data = 32'h14; // sel 1 sees a 1 while stored bit is 0
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 write cycle", 64'(evt), 64'h0);
    @(negedge clk);
    check("R9 sel change", 64'(evt), 64'h0);
    @(negedge clk);
    check("R9 after", 64'(evt), 64'h0);
    cnt = 64'h1;
    write_cfg(32'h0);
    wr_en = 1'b1; wr_data = 32'h04; // enable with bit0 already 1
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check("R9 enable on", 64'(evt), 64'h0);
    poke("R9 live after rearm", 0, 1'b0, 1'b0);
    poke("R9 rise after rearm", 0, 1'b1, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_disabled();
    t_scale();
    t_no_ext();
    t_rearm();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule